// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block turns the event lines of a set of condition units into one ordered trigger decision for a capture buffer. The programmed rule is a chain of up to eight levels. Each level watches one selected event line. It may require that line on a programmed number of sample ticks. It may also put a time limit on that line, either a deadline or a minimum wait, measured in ticks from the moment the level was entered. The chain is walked strictly in order. When the final level is met, the block issues one trigger pulse and then waits in a finished state.

Software loads the per-level fields and pulses `arm`. The sequencer then starts at level 0. All counting and all decisions happen only on clock edges where `sampleTick` is high. With this one block the capture logic can express rules such as "A, then B n times, then C within T ticks".

Per-level fields sit in flat vectors, with level k at slice `[k*W +: W]`. These fields are:
- `cfgSel`: the index of the event line the level watches.
- `cfgCount`: the required number of occurrences.
- `cfgTimer`: the limit T, in ticks.
- `cfgMode`: the timer mode. 0 means no timer, 1 means deadline, 2 means minimum wait, and 3 is treated as 0.
- `cfgLast`: marks the final level.

Top module: `trig_seq`

## Requirements
- R1: After reset, and until `arm` is pulsed, `level` is 0 and `trigger` and `done` are 0. Ticks and events have no effect in this state.
- R2: A cycle with `arm` high moves the sequencer to running at level 0 with cleared counters, from any state. The result is visible after that edge.
- R3: Levels are taken strictly in order, one step per satisfying tick. Edges without `sampleTick` change nothing. Events on lines other than the selected one are ignored.
- R4: A level is satisfied on the tick that brings its qualifying occurrences to `cfgCount`. A count of 0 behaves like 1.
- R5: The tick that satisfies a level is not counted toward the next level, even when both levels watch the same line.
- R6: In deadline mode (1), the level's tick age is 1 on the first tick after the level is entered. A selected event counts only at ages 1 to T. If the level is unsatisfied when a tick of age T+1 arrives, the sequencer returns to level 0 and clears its counters.
- R7: In minimum-wait mode (2), selected events at tick ages 1 to T are ignored. Events count from age T+1 onward.
- R8: Satisfying a level whose `cfgLast` bit is set, or satisfying level 7, raises `trigger` for exactly the one cycle after that tick's edge. At the same edge `done` rises, and `level` keeps the final level's index.
- R9: While `done` is high, no further trigger occurs and `level` holds, whatever the ticks and events, until `arm` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart the sequence at level 0 |
| sampleTick | input | 1 | Qualifies the edges at which events are evaluated and timers advance |
| events | input | 8 | Event lines from the condition units |
| cfgSel | input | 24 | Per-level event select, 3 bits per level |
| cfgCount | input | 64 | Per-level occurrence count, 8 bits per level |
| cfgTimer | input | 128 | Per-level timer limit T in ticks, 16 bits per level |
| cfgMode | input | 16 | Per-level timer mode, 2 bits per level |
| cfgLast | input | 8 | Per-level final-level flag |
| trigger | output | 1 | One-cycle trigger pulse |
| level | output | 3 | Index of the level currently awaited |
| done | output | 1 | High once the sequence has fired, until re-armed |

## Verification
Every result of this block is due one edge after its cause. A tick, an event, or an `arm` pulse is sampled at a rising edge, and the new `level`, `done` and `trigger` values are registered at that same edge. The trigger pulse then falls at the next edge. The bench changes inputs on the falling edge and advances exactly one rising edge per step. It compares all three outputs 1 ns after that edge, so each check lands in the cycle where the result first appears. Timer windows are checked at their exact edges, ages T and T+1.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    TM_NONE   = 2'd0,
    TM_WITHIN = 2'd1,
    TM_AFTER  = 2'd2
  } timerMode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;     // clear occurrence and timer counters
    logic incOcc;  // one more qualifying occurrence
    logic incTmr;  // one more tick spent in this level
  } dpStrobe_t;

endpackage

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int NUM_EVENTS = 8,
  parameter int MAX_LEVELS = 8,
  parameter int CNT_W      = 8,
  parameter int TMR_W      = 16,
  localparam int SEL_W     = $clog2(NUM_EVENTS),
  localparam int LVL_W     = $clog2(MAX_LEVELS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LVL_W-1:0]            level,
  input  dpStrobe_t                   strb,
  input  logic [NUM_EVENTS-1:0]       events,
  input  logic [MAX_LEVELS*SEL_W-1:0] cfgSel,
  input  logic [MAX_LEVELS*CNT_W-1:0] cfgCount,
  input  logic [MAX_LEVELS*TMR_W-1:0] cfgTimer,
  input  logic [MAX_LEVELS*2-1:0]     cfgMode,
  input  logic [MAX_LEVELS-1:0]       cfgLast,
  output logic                        hit,
  output logic                        countMet,
  output logic                        expired,
  output timerMode_t                  curMode,
  output logic                        isLast
);

  logic [SEL_W-1:0] selArr   [MAX_LEVELS];
  logic [CNT_W-1:0] countArr [MAX_LEVELS];
  logic [TMR_W-1:0] timerArr [MAX_LEVELS];
  logic [1:0]       modeArr  [MAX_LEVELS];

  genvar k;
  generate
    for (k = 0; k < MAX_LEVELS; k++) begin : g_unpack
      assign selArr[k]   = cfgSel[k*SEL_W +: SEL_W];
      assign countArr[k] = cfgCount[k*CNT_W +: CNT_W];
      assign timerArr[k] = cfgTimer[k*TMR_W +: TMR_W];
      assign modeArr[k]  = cfgMode[k*2 +: 2];
    end
  endgenerate

  logic [CNT_W-1:0] occCnt;
  logic [TMR_W-1:0] tmrCnt;
  logic [CNT_W:0]   needCnt;
  logic [CNT_W-1:0] curCount;

  always_comb begin
    curCount = countArr[level];
    needCnt  = (curCount == '0) ? (CNT_W+1)'(1) : {1'b0, curCount};
    hit      = events[selArr[level]];
    countMet = ({1'b0, occCnt} + (CNT_W+1)'(1)) >= needCnt;
    expired  = tmrCnt >= timerArr[level];
    isLast   = cfgLast[level];
    case (modeArr[level])
      2'd1:    curMode = TM_WITHIN;
      2'd2:    curMode = TM_AFTER;
      default: curMode = TM_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      occCnt <= '0;
      tmrCnt <= '0;
    end else begin
      if (strb.incOcc) occCnt <= occCnt + CNT_W'(1);
      if (strb.incTmr && tmrCnt != '1) tmrCnt <= tmrCnt + TMR_W'(1);
    end
  end

  // R2: a clear strobe leaves both counters at zero
  assert_clr_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (occCnt == '0 && tmrCnt == '0));

  // R3: the timer moves only when control spends a tick
  assert_tmr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incTmr && !strb.clr) |=> $stable(tmrCnt));

  // R4: the occurrence counter moves only on a qualifying occurrence
  assert_occ_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incOcc && !strb.clr) |=> $stable(occCnt));

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int MAX_LEVELS = 8,
  localparam int LVL_W     = $clog2(MAX_LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             sampleTick,
  input  logic             hit,
  input  logic             countMet,
  input  logic             expired,
  input  timerMode_t       curMode,
  input  logic             isLast,
  output dpStrobe_t        strb,
  output logic [LVL_W-1:0] level,
  output logic             trigger,
  output logic             done
);

  seqState_t        state, nextState;
  logic [LVL_W-1:0] nextLevel;
  logic             trigNext;
  logic             qualify;
  logic             finalLevel;

  always_comb begin
    qualify    = hit && (curMode != TM_AFTER || expired);
    finalLevel = isLast || (level == LVL_W'(MAX_LEVELS-1));
    nextState  = state;
    nextLevel  = level;
    trigNext   = 1'b0;
    strb       = '0;
    if (arm) begin
      nextState = ST_RUN;
      nextLevel = '0;
      strb.clr  = 1'b1;
    end else if (state == ST_RUN && sampleTick) begin
      if (curMode == TM_WITHIN && expired) begin
        nextLevel = '0;
        strb.clr  = 1'b1;
      end else if (qualify && countMet) begin
        strb.clr = 1'b1;
        if (finalLevel) begin
          nextState = ST_DONE;
          trigNext  = 1'b1;
        end else begin
          nextLevel = level + LVL_W'(1);
        end
      end else begin
        strb.incOcc = qualify;
        strb.incTmr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      level   <= '0;
      trigger <= 1'b0;
    end else begin
      state   <= nextState;
      level   <= nextLevel;
      trigger <= trigNext;
    end
  end

  assign done = (state == ST_DONE);

  // R1: idle holds level 0 until armed
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !arm) |=> (state == ST_IDLE && level == '0));

  // R3: a running level only stays, steps by one, or restarts at 0
  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !arm) |=>
      (level == $past(level) || level == $past(level) + LVL_W'(1) || level == '0));

  // R3: no tick, no change of level
  assert_no_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !arm && !sampleTick) |=> $stable(level));

  // R8: trigger is a single-cycle pulse that arrives with done
  assert_trig_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (done && $rose(done)));

  // R9: finished state holds without trigger until armed
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !arm) |=> (state == ST_DONE && !trigger && $stable(level)));

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int NUM_EVENTS = 8,
  parameter int MAX_LEVELS = 8,
  parameter int CNT_W      = 8,
  parameter int TMR_W      = 16,
  localparam int SEL_W     = $clog2(NUM_EVENTS),
  localparam int LVL_W     = $clog2(MAX_LEVELS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        arm,
  input  logic                        sampleTick,
  input  logic [NUM_EVENTS-1:0]       events,
  input  logic [MAX_LEVELS*SEL_W-1:0] cfgSel,
  input  logic [MAX_LEVELS*CNT_W-1:0] cfgCount,
  input  logic [MAX_LEVELS*TMR_W-1:0] cfgTimer,
  input  logic [MAX_LEVELS*2-1:0]     cfgMode,
  input  logic [MAX_LEVELS-1:0]       cfgLast,
  output logic                        trigger,
  output logic [LVL_W-1:0]            level,
  output logic                        done
);

  dpStrobe_t  strb;
  logic       hit, countMet, expired, isLast;
  timerMode_t curMode;

  trig_seq_dp #(
    .NUM_EVENTS(NUM_EVENTS), .MAX_LEVELS(MAX_LEVELS),
    .CNT_W(CNT_W), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .level(level), .strb(strb), .events(events),
    .cfgSel(cfgSel), .cfgCount(cfgCount), .cfgTimer(cfgTimer),
    .cfgMode(cfgMode), .cfgLast(cfgLast),
    .hit(hit), .countMet(countMet), .expired(expired),
    .curMode(curMode), .isLast(isLast)
  );

  trig_seq_ctrl #(.MAX_LEVELS(MAX_LEVELS)) u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleTick(sampleTick),
    .hit(hit), .countMet(countMet), .expired(expired),
    .curMode(curMode), .isLast(isLast),
    .strb(strb), .level(level), .trigger(trigger), .done(done)
  );

endmodule

// File: tb/trig_seq_test.sv
module trig_seq_test;

  logic         clk = 1'b0;
  logic         rstN;
  logic         arm, sampleTick;
  logic [7:0]   events;
  logic [23:0]  cfgSel;
  logic [63:0]  cfgCount;
  logic [127:0] cfgTimer;
  logic [15:0]  cfgMode;
  logic [7:0]   cfgLast;
  logic         trigger, done;
  logic [2:0]   level;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  trig_seq uut (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleTick(sampleTick), .events(events),
    .cfgSel(cfgSel), .cfgCount(cfgCount), .cfgTimer(cfgTimer),
    .cfgMode(cfgMode), .cfgLast(cfgLast),
    .trigger(trigger), .level(level), .done(done)
  );

  typedef struct packed {
    logic       a;
    logic       t;
    logic [7:0] ev;
    logic [2:0] lvl;
    logic       trg;
    logic       dn;
    logic [3:0] req;
  } vec_t;

  // Config A: L0 line0 x1; L1 line1 x3; L2 line2 x1 deadline T=2, last
  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 8'h01, 3'd0, 1'b0, 1'b0, 4'd1}, // R1 idle ignores tick
    '{1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 4'd2}, // R2 arm
    '{1'b0, 1'b0, 8'h01, 3'd0, 1'b0, 1'b0, 4'd3}, // R3 no tick
    '{1'b0, 1'b1, 8'h02, 3'd0, 1'b0, 1'b0, 4'd3}, // R3 other line
    '{1'b0, 1'b1, 8'h03, 3'd1, 1'b0, 1'b0, 4'd5}, // R5 line1 not counted
    '{1'b0, 1'b1, 8'h02, 3'd1, 1'b0, 1'b0, 4'd4}, // R4 occ 1
    '{1'b0, 1'b0, 8'h02, 3'd1, 1'b0, 1'b0, 4'd3}, // R3 no tick
    '{1'b0, 1'b1, 8'h02, 3'd1, 1'b0, 1'b0, 4'd4}, // R4 occ 2
    '{1'b0, 1'b1, 8'h02, 3'd2, 1'b0, 1'b0, 4'd4}, // R4 occ 3 advances
    '{1'b0, 1'b1, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6}, // R6 age 1
    '{1'b0, 1'b1, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6}, // R6 age 2
    '{1'b0, 1'b1, 8'h04, 3'd0, 1'b0, 1'b0, 4'd6}, // R6 age 3 expires
    '{1'b0, 1'b1, 8'h01, 3'd1, 1'b0, 1'b0, 4'd6}, // R6 counters cleared
    '{1'b0, 1'b1, 8'h02, 3'd1, 1'b0, 1'b0, 4'd4},
    '{1'b0, 1'b1, 8'h02, 3'd1, 1'b0, 1'b0, 4'd4},
    '{1'b0, 1'b1, 8'h02, 3'd2, 1'b0, 1'b0, 4'd4},
    '{1'b0, 1'b1, 8'h00, 3'd2, 1'b0, 1'b0, 4'd6}, // R6 age 1
    '{1'b0, 1'b1, 8'h04, 3'd2, 1'b1, 1'b1, 4'd8}, // R8 age 2 fires
    '{1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b1, 4'd8}, // R8 one-cycle pulse
    '{1'b0, 1'b1, 8'h07, 3'd2, 1'b0, 1'b1, 4'd9}, // R9 done holds
    '{1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 4'd2}  // R2 re-arm
  };

  task automatic check(input logic [2:0] expLvl, input logic expTrg,
                       input logic expDn, input string req);
    checkCount++;
    if (level !== expLvl || trigger !== expTrg || done !== expDn) begin
      failCount++;
      $display("FAIL %s: level=%0d trigger=%0b done=%0b expected level=%0d trigger=%0b done=%0b",
               req, level, trigger, done, expLvl, expTrg, expDn);
    end
  endtask

  task automatic step(input logic a, input logic t, input logic [7:0] ev);
    @(negedge clk);
    arm = a; sampleTick = t; events = ev;
    @(posedge clk);
    #1;
  endtask

  task automatic setLevel(input int k, input logic [2:0] sel, input logic [7:0] cnt,
                          input logic [15:0] tmr, input logic [1:0] mode, input logic last);
    cfgSel[k*3 +: 3]     = sel;
    cfgCount[k*8 +: 8]   = cnt;
    cfgTimer[k*16 +: 16] = tmr;
    cfgMode[k*2 +: 2]    = mode;
    cfgLast[k]           = last;
  endtask

  task automatic clearCfg();
    cfgSel = '0; cfgCount = '0; cfgTimer = '0; cfgMode = '0; cfgLast = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; arm = 1'b0; sampleTick = 1'b0; events = '0;
    clearCfg();
    setLevel(0, 3'd0, 8'd1, 16'd0, 2'd0, 1'b0);
    setLevel(1, 3'd1, 8'd3, 16'd0, 2'd0, 1'b0);
    setLevel(2, 3'd2, 8'd1, 16'd2, 2'd1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(3'd0, 1'b0, 1'b0, "R1 reset state");

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].a, VECS[i].t, VECS[i].ev);
      check(VECS[i].lvl, VECS[i].trg, VECS[i].dn, $sformatf("R%0d vec %0d", VECS[i].req, i));
    end

    // R7: minimum wait of 2 ticks at level 1
    clearCfg();
    setLevel(0, 3'd0, 8'd1, 16'd0, 2'd0, 1'b0);
    setLevel(1, 3'd3, 8'd1, 16'd2, 2'd2, 1'b1);
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h09); check(3'd1, 1'b0, 1'b0, "R7 entry");
    step(1'b0, 1'b1, 8'h08); check(3'd1, 1'b0, 1'b0, "R7 age 1 ignored");
    step(1'b0, 1'b1, 8'h08); check(3'd1, 1'b0, 1'b0, "R7 age 2 ignored");
    step(1'b0, 1'b1, 8'h08); check(3'd1, 1'b1, 1'b1, "R7 age 3 counts");

    // R4 count 0 as 1; R5 same line on consecutive levels
    clearCfg();
    setLevel(0, 3'd5, 8'd0, 16'd0, 2'd0, 1'b0);
    setLevel(1, 3'd5, 8'd2, 16'd0, 2'd0, 1'b1);
    step(1'b1, 1'b0, 8'h00); check(3'd0, 1'b0, 1'b0, "R2 re-arm from done");
    step(1'b0, 1'b1, 8'h20); check(3'd1, 1'b0, 1'b0, "R4 count 0 acts as 1");
    step(1'b0, 1'b1, 8'h20); check(3'd1, 1'b0, 1'b0, "R5 same line not double counted");
    step(1'b0, 1'b1, 8'h20); check(3'd1, 1'b1, 1'b1, "R5 second occurrence fires");

    // R8: no last flag, chain runs through all eight levels
    clearCfg();
    for (int k = 0; k < 8; k++) setLevel(k, 3'(k), 8'd1, 16'd0, 2'd0, 1'b0);
    step(1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 8'(1 << k));
      if (k < 7) check(3'(k + 1), 1'b0, 1'b0, "R3 in-order step");
      else       check(3'd7, 1'b1, 1'b1, "R8 level 7 ends sequence");
    end

    // R2: arm mid-run restarts at level 0
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h01); check(3'd1, 1'b0, 1'b0, "R3 first level");
    step(1'b1, 1'b1, 8'h02); check(3'd0, 1'b0, 1'b0, "R2 arm mid-run restarts");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule